// File: doc/BRIEF.md
# Field-Synchronised Video Capture Register Bank

This block is the register bank beside a video capture port. Software reaches it through a plain 32-bit word-addressed read/write port. The capture logic drives strobes into it: start of field (with the field's parity), start of line, and "a data word was stored to memory". The bank keeps one memory base address for odd fields and one for even fields. Each base address is shadowed. A software write only loads a pending copy and raises a flag. Both active addresses are replaced together on the first stored data word of the next field, so the capture engine never switches address partway through a field.

The bank also counts lines within the current field and pulses an interrupt when the count reaches a programmable target. It latches that event in a sticky bit, which software clears by writing 1. It holds two 24-bit masks, one per field parity, that choose which of the first 24 received lines (the blanking-interval lines) are passed straight to the TV output path. The pass decision for the current line is output as a single bit.

Top module: `vcap_regbank`

Register word addresses: 0 status, 1 current line, 2 line target, 3 odd-field line mask, 4 even-field line mask, 5 odd base, 6 even base. Addresses 7 and up read 0, and writes to them are ignored. Status bits: bit 0 run (live copy of `cap_run`), bit 1 storing, bit 2 base update pending, bit 3 line interrupt seen (write 1 to clear).

## Requirements
- R1: A write to address 5 or 6 loads only the pending copy of that base. `base_odd_o` and `base_even_o`, and reads of addresses 5 and 6, keep returning the active value until a commit.
- R2: Any write to address 5 or 6 sets status bit 2 in the next cycle.
- R3: A commit happens on the first `data_store` after a `field_start`. A `data_store` in the same cycle as `field_start` does not count. On a commit, both pending bases are copied into the active bases together and status bit 2 is cleared. Later `data_store` pulses in the same field, and `data_store` before any field has started, commit nothing.
- R4: Base addresses are 16-byte aligned. Bits [3:0] of the pending and active bases are always 0, whatever is written.
- R5: The current line (address 1, bits [9:0]) clears to 0 on `field_start` and otherwise increments on each `line_start`. Writes to address 1 have no effect.
- R6: The line count saturates at 1023. A further `line_start` leaves it at 1023.
- R7: The line target (address 2, bits [9:0]) is read/write. `irq_o` is high for one cycle, in the cycle after a strobe that moves the count to the target: a `line_start` that changes the count, or a `field_start` when the target is 0.
- R8: Status bit 3 is set by each line-target event and cleared by writing 1 to bit 3 of address 0. If a set and a clear fall in the same cycle, the set wins.
- R9: Addresses 3 and 4 hold 24-bit masks. Bits [31:24] read 0. The field parity is latched from `field_odd` (1 means odd) at `field_start`. `vbi_pass_o` equals bit L of the current field's mask while the line count L is below 24, and is 0 otherwise.
- R10: Status bit 0 follows `cap_run`. Status bit 1 is set by `data_store` and cleared by `field_start` or by `cap_run` being low.
- R11: After reset, every register, the pending copies, the line count, the parity (even), the status bits and all outputs are 0.
- R12: If a base write falls in the same cycle as a commit, the commit moves the previously pending values. The newly written value stays pending and status bit 2 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cap_run | input | 1 | Capture engine running |
| field_start | input | 1 | A new field begins |
| field_odd | input | 1 | Parity of the starting field, 1 = odd |
| line_start | input | 1 | A new line begins |
| data_store | input | 1 | A data word was stored to memory |
| base_odd_o | output | 32 | Active odd-field base address |
| base_even_o | output | 32 | Active even-field base address |
| vbi_pass_o | output | 1 | Current line passes to the TV output path |
| irq_o | output | 1 | Line-target interrupt pulse |

## Verification
The hardest state to reach from the ports is a base write landing in exactly the cycle of a commit, together with the related case of a write that arrives after the field's first stored word. In that case the write must wait a whole further field. The stimulus gets there by pairing the write strobe with the first `data_store` of a field, and by writing between two `data_store` pulses of one field, then opening further fields. Line-count saturation at 1023, with a target of 1023 that must fire exactly once, is reached by a run of more than a thousand back-to-back `line_start` pulses. A long random phase then mixes writes, strobes and mid-field target changes against the reference model.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_STATUS    = 3'd0,
      RA_LINE      = 3'd1,
      RA_TARGET    = 3'd2,
      RA_VBI_ODD   = 3'd3,
      RA_VBI_EVEN  = 3'd4,
      RA_BASE_ODD  = 3'd5,
      RA_BASE_EVEN = 3'd6
   } reg_addr_e;

   localparam int ST_RUN     = 0;
   localparam int ST_STORING = 1;
   localparam int ST_PEND    = 2;
   localparam int ST_IRQ     = 3;

   localparam int NUM_FIELDS = 2;
   localparam int FLD_ODD    = 0;
   localparam int FLD_EVEN   = 1;

endpackage

// File: rtl/vcap_base_shadow.sv
module vcap_base_shadow #(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wdata,
   input  logic              commit,
   output logic [ADDR_W-1:0] active_o
);

   localparam int HI_W = ADDR_W - ALIGN_BITS;

   if (ALIGN_BITS < 0 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
      $error("vcap_base_shadow: ALIGN_BITS out of range");
   end

   logic [HI_W-1:0] pend_q;
   logic [HI_W-1:0] act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         if (commit) act_q  <= pend_q;
         if (wr_en)  pend_q <= wdata[ADDR_W-1:ALIGN_BITS];
      end
   end

   if (ALIGN_BITS > 0) begin : g_pad
      assign active_o = {act_q, {ALIGN_BITS{1'b0}}};
   end else begin : g_nopad
      assign active_o = act_q;
   end

   AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active_o)); // R1

   AST_COMMIT_TAKES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> active_o[ADDR_W-1:ALIGN_BITS] == $past(pend_q)); // R3

endmodule

// File: rtl/vcap_line_ctr.sv
module vcap_line_ctr #(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_start,
   input  logic              line_start,
   input  logic [LINE_W-1:0] target,
   output logic [LINE_W-1:0] line_o,
   output logic              irq_evt_o,
   output logic              irq_o
);

   localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

   if (LINE_W < 1) begin : g_bad_w
      $error("vcap_line_ctr: LINE_W must be positive");
   end

   logic [LINE_W-1:0] cnt_q;
   logic              irq_q;
   logic              can_step;

   assign can_step  = line_start && (cnt_q != LINE_MAX);
   assign irq_evt_o = field_start ? (target == '0)
                                  : (can_step && ((cnt_q + 1'b1) == target));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= irq_evt_o;
         if (field_start)   cnt_q <= '0;
         else if (can_step) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign line_o = cnt_q;
   assign irq_o  = irq_q;

   AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> line_o == '0); // R5

   AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!field_start && line_start && line_o != LINE_MAX) |=> line_o == $past(line_o) + 1'b1); // R5

   AST_LINE_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!field_start && line_o == LINE_MAX) |=> line_o == LINE_MAX); // R6

   AST_IRQ_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> line_o == $past(target)); // R7

endmodule

// File: rtl/vcap_regbank.sv
module vcap_regbank
   import vcap_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 4,
   parameter int LINE_W     = 10,
   parameter int VBI_LINES  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              cap_run,
   input  logic              field_start,
   input  logic              field_odd,
   input  logic              line_start,
   input  logic              data_store,
   output logic [ADDR_W-1:0] base_odd_o,
   output logic [ADDR_W-1:0] base_even_o,
   output logic              vbi_pass_o,
   output logic              irq_o
);

   localparam int VBI_IW = (VBI_LINES > 1) ? $clog2(VBI_LINES) : 1;
   localparam logic [LINE_W-1:0] VBI_LIM = LINE_W'(VBI_LINES);

   if (ADDR_W > DATA_W)                   begin : g_bad_addr $error("vcap_regbank: ADDR_W exceeds DATA_W"); end
   if (VBI_LINES > DATA_W)                begin : g_bad_vbi  $error("vcap_regbank: VBI_LINES exceeds DATA_W"); end
   if (LINE_W > DATA_W)                   begin : g_bad_line $error("vcap_regbank: LINE_W exceeds DATA_W"); end
   if (VBI_LINES >= (1 << LINE_W))        begin : g_bad_lim  $error("vcap_regbank: VBI_LINES not countable"); end
   if (DATA_W <= ST_IRQ)                  begin : g_bad_dw   $error("vcap_regbank: DATA_W too narrow for status"); end

   // ---------------- write decode ----------------
   logic sts_wr, tgt_wr;
   logic [NUM_FIELDS-1:0] base_wr;
   logic [NUM_FIELDS-1:0] mask_wr;

   assign sts_wr = reg_wr && (reg_addr == RA_STATUS);
   assign tgt_wr = reg_wr && (reg_addr == RA_TARGET);
   assign base_wr[FLD_ODD]  = reg_wr && (reg_addr == RA_BASE_ODD);
   assign base_wr[FLD_EVEN] = reg_wr && (reg_addr == RA_BASE_EVEN);
   assign mask_wr[FLD_ODD]  = reg_wr && (reg_addr == RA_VBI_ODD);
   assign mask_wr[FLD_EVEN] = reg_wr && (reg_addr == RA_VBI_EVEN);

   // ---------------- field tracking and commit ----------------
   logic first_q, commit, pend_q, storing_q, cur_odd_q;

   assign commit = data_store && first_q && !field_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q   <= 1'b0;
         pend_q    <= 1'b0;
         storing_q <= 1'b0;
         cur_odd_q <= 1'b0;
      end else begin
         if (field_start)     first_q <= 1'b1;
         else if (data_store) first_q <= 1'b0;

         if (|base_wr)    pend_q <= 1'b1;
         else if (commit) pend_q <= 1'b0;

         if (!cap_run || field_start) storing_q <= 1'b0;
         else if (data_store)         storing_q <= 1'b1;

         if (field_start) cur_odd_q <= field_odd;
      end
   end

   // ---------------- shadowed bases and line masks ----------------
   logic [ADDR_W-1:0]    base_act [NUM_FIELDS];
   logic [VBI_LINES-1:0] mask_q   [NUM_FIELDS];

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      vcap_base_shadow #(
         .ADDR_W     (ADDR_W),
         .ALIGN_BITS (ALIGN_BITS)
      ) i_base (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (base_wr[f]),
         .wdata    (reg_wdata[ADDR_W-1:0]),
         .commit   (commit),
         .active_o (base_act[f])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)          mask_q[f] <= '0;
         else if (mask_wr[f]) mask_q[f] <= reg_wdata[VBI_LINES-1:0];
      end
   end

   assign base_odd_o  = base_act[FLD_ODD];
   assign base_even_o = base_act[FLD_EVEN];

   // ---------------- line counter and interrupt ----------------
   logic [LINE_W-1:0] target_q, line_cnt;
   logic              irq_evt, sticky_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      target_q <= '0;
      else if (tgt_wr) target_q <= reg_wdata[LINE_W-1:0];
   end

   vcap_line_ctr #(
      .LINE_W (LINE_W)
   ) i_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .field_start (field_start),
      .line_start  (line_start),
      .target      (target_q),
      .line_o      (line_cnt),
      .irq_evt_o   (irq_evt),
      .irq_o       (irq_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                          sticky_q <= 1'b0;
      else if (irq_evt)                    sticky_q <= 1'b1;
      else if (sts_wr && reg_wdata[ST_IRQ]) sticky_q <= 1'b0;
   end

   // ---------------- line pass-through ----------------
   logic [VBI_LINES-1:0] cur_mask;
   assign cur_mask   = cur_odd_q ? mask_q[FLD_ODD] : mask_q[FLD_EVEN];
   assign vbi_pass_o = (line_cnt < VBI_LIM) && cur_mask[line_cnt[VBI_IW-1:0]];

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_STATUS: begin
            reg_rdata[ST_RUN]     = cap_run;
            reg_rdata[ST_STORING] = storing_q;
            reg_rdata[ST_PEND]    = pend_q;
            reg_rdata[ST_IRQ]     = sticky_q;
         end
         RA_LINE:      reg_rdata[LINE_W-1:0]    = line_cnt;
         RA_TARGET:    reg_rdata[LINE_W-1:0]    = target_q;
         RA_VBI_ODD:   reg_rdata[VBI_LINES-1:0] = mask_q[FLD_ODD];
         RA_VBI_EVEN:  reg_rdata[VBI_LINES-1:0] = mask_q[FLD_EVEN];
         RA_BASE_ODD:  reg_rdata[ADDR_W-1:0]    = base_act[FLD_ODD];
         RA_BASE_EVEN: reg_rdata[ADDR_W-1:0]    = base_act[FLD_EVEN];
         default:      reg_rdata = '0;
      endcase
   end

   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|base_wr) |=> pend_q); // R2

   AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !(|base_wr)) |=> !pend_q); // R3

   AST_NO_LATE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!first_q && !(|base_wr)) |=> $stable(base_odd_o) && $stable(base_even_o)); // R3

   AST_STICKY_FOLLOWS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> sticky_q); // R8

   AST_STORING_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_run |=> !storing_q); // R10

endmodule

// File: tb/test_vcap_regbank.sv
module test_vcap_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cap_run = 1'b0, field_start = 1'b0, field_odd = 1'b0;
   logic        line_start = 1'b0, data_store = 1'b0;
   logic [31:0] base_odd_o, base_even_o;
   logic        vbi_pass_o, irq_o;

   always #2 clk = ~clk; // 250 MHz

   vcap_regbank i_vcap_regbank (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_run(cap_run),
      .field_start(field_start), .field_odd(field_odd), .line_start(line_start),
      .data_store(data_store), .base_odd_o(base_odd_o), .base_even_o(base_even_o),
      .vbi_pass_o(vbi_pass_o), .irq_o(irq_o)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   int unsigned m_pend_o, m_pend_e, m_act_o, m_act_e, m_mask_o, m_mask_e;
   int m_line, m_tgt;
   bit m_pflag, m_first, m_sticky, m_irq, m_odd, m_storing;

   task automatic model_reset();
      m_pend_o = 0; m_pend_e = 0; m_act_o = 0; m_act_e = 0;
      m_mask_o = 0; m_mask_e = 0; m_line = 0; m_tgt = 0;
      m_pflag = 0; m_first = 0; m_sticky = 0; m_irq = 0; m_odd = 0; m_storing = 0;
   endtask

   task automatic model_step();
      bit evt, commit;
      evt = field_start ? (m_tgt == 0)
                        : (line_start && m_line != 1023 && m_line + 1 == m_tgt);
      commit = data_store && m_first && !field_start;
      if (commit) begin
         m_act_o = m_pend_o; m_act_e = m_pend_e; m_pflag = 0;
      end
      if (reg_wr && reg_addr == 5) begin m_pend_o = reg_wdata & 32'hFFFF_FFF0; m_pflag = 1; end
      if (reg_wr && reg_addr == 6) begin m_pend_e = reg_wdata & 32'hFFFF_FFF0; m_pflag = 1; end
      if (reg_wr && reg_addr == 3) m_mask_o = reg_wdata & 32'h00FF_FFFF;
      if (reg_wr && reg_addr == 4) m_mask_e = reg_wdata & 32'h00FF_FFFF;
      if (evt) m_sticky = 1;
      else if (reg_wr && reg_addr == 0 && reg_wdata[3]) m_sticky = 0;
      if (reg_wr && reg_addr == 2) m_tgt = int'(reg_wdata[9:0]);
      m_irq = evt;
      if (field_start) m_first = 1; else if (data_store) m_first = 0;
      if (!cap_run || field_start) m_storing = 0; else if (data_store) m_storing = 1;
      if (field_start) m_odd = field_odd;
      if (field_start) m_line = 0;
      else if (line_start && m_line < 1023) m_line = m_line + 1;
   endtask

   function automatic int unsigned model_read(input logic [2:0] a);
      case (a)
         3'd0: return {28'd0, m_sticky, m_pflag, m_storing, cap_run};
         3'd1: return m_line;
         3'd2: return m_tgt;
         3'd3: return m_mask_o;
         3'd4: return m_mask_e;
         3'd5: return m_act_o;
         3'd6: return m_act_e;
         default: return 0;
      endcase
   endfunction

   function automatic string read_req(input logic [2:0] a);
      case (a)
         3'd0: return "R2/R8/R10 status";
         3'd1: return "R5 line";
         3'd2: return "R7 target";
         3'd3, 3'd4: return "R9 mask";
         3'd5, 3'd6: return "R1/R4 base";
         default: return "R11 unmapped";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit exp_pass;
      int unsigned msk;
      msk = m_odd ? m_mask_o : m_mask_e;
      exp_pass = (m_line < 24) ? msk[m_line] : 1'b0;
      chk(base_odd_o  == m_act_o, "R1/R3 base_odd_o",  base_odd_o,  m_act_o);
      chk(base_even_o == m_act_e, "R1/R3 base_even_o", base_even_o, m_act_e);
      chk(irq_o == m_irq, "R7 irq_o", {31'd0, irq_o}, {31'd0, m_irq});
      chk(vbi_pass_o == exp_pass, "R9 vbi_pass_o", {31'd0, vbi_pass_o}, {31'd0, exp_pass});
      chk(reg_rdata == model_read(reg_addr), read_req(reg_addr), reg_rdata, model_read(reg_addr));
   endtask

   // one clock: drive inputs (at a falling edge), update model at rising edge, compare at next falling edge
   task automatic cyc(input bit wr = 0, input logic [2:0] a = 0, input logic [31:0] d = 0,
                      input bit fs = 0, input bit fo = 0, input bit ls = 0, input bit ds = 0);
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      field_start = fs; field_odd = fo; line_start = ls; data_store = ds;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic rd(input logic [2:0] a);
      cyc(0, a);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state of every register and output
      for (int a = 0; a < 8; a++) rd(3'(a));

      cap_run = 1'b1;
      // R1, R2, R4: base write goes to pending only, low bits dropped
      cyc(1, 3'd5, 32'h1234_567F);
      rd(3'd5); rd(3'd0);
      // R3: data_store before any field start commits nothing
      cyc(0, 3'd5, 0, 0, 0, 0, 1);
      // R3: store in the field_start cycle does not count; next one commits
      cyc(0, 3'd5, 0, 1, 1, 0, 1);
      rd(3'd0);
      cyc(0, 3'd5, 0, 0, 0, 0, 1);
      rd(3'd5); rd(3'd0);
      // R3: write after first store of a field waits for next field
      cyc(1, 3'd6, 32'hABCD_EF01);
      cyc(0, 3'd6, 0, 0, 0, 0, 1);
      rd(3'd6);
      cyc(0, 3'd6, 0, 1, 0);
      cyc(0, 3'd6, 0, 0, 0, 0, 1);
      rd(3'd6); rd(3'd0);
      // R12: write in the same cycle as a commit stays pending
      cyc(1, 3'd5, 32'h0000_1110);
      cyc(0, 3'd0, 0, 1, 1);
      cyc(1, 3'd5, 32'h0000_2220, 0, 0, 0, 1);
      rd(3'd0); rd(3'd5);
      cyc(0, 3'd0, 0, 1, 0);
      cyc(0, 3'd5, 0, 0, 0, 0, 1);
      rd(3'd0);

      // R5, R7, R8: line count, target interrupt, sticky W1C
      cyc(1, 3'd2, 32'hFFFF_FC03);
      cyc(1, 3'd1, 32'h0000_0155); // R5 write to line ignored
      rd(3'd1);
      cyc(0, 3'd1, 0, 1, 0);
      for (int i = 0; i < 6; i++) cyc(0, 3'd1, 0, 0, 0, 1);
      rd(3'd0);
      cyc(1, 3'd0, 32'h8);
      rd(3'd0);
      // R8: set and clear in the same cycle - set wins
      cyc(1, 3'd2, 32'd0);
      cyc(1, 3'd0, 32'h8, 1, 0);
      rd(3'd0);
      cyc(1, 3'd0, 32'h8);

      // R6: saturation at 1023, target 1023 fires once
      cyc(1, 3'd2, 32'd1023);
      cyc(0, 3'd1, 0, 1, 0);
      for (int i = 0; i < 1030; i++) cyc(0, 3'd1, 0, 0, 0, 1);
      rd(3'd1); rd(3'd0);
      cyc(1, 3'd0, 32'h8);

      // R9: line masks on odd and even fields
      cyc(1, 3'd3, 32'hFF5A_A5C3);
      cyc(1, 3'd4, 32'h123C_0F81);
      rd(3'd3); rd(3'd4);
      cyc(0, 3'd3, 0, 1, 1);
      for (int i = 0; i < 27; i++) cyc(0, 3'd3, 0, 0, 0, 1);
      cyc(0, 3'd4, 0, 1, 0);
      for (int i = 0; i < 27; i++) cyc(0, 3'd4, 0, 0, 0, 1);

      // R10: run and storing status
      cyc(0, 3'd0, 0, 1, 1);
      cyc(0, 3'd0, 0, 0, 0, 0, 1);
      rd(3'd0);
      cap_run = 1'b0;
      rd(3'd0); rd(3'd0);
      cap_run = 1'b1;
      cyc(0, 3'd0, 0, 0, 0, 0, 1);
      cyc(0, 3'd0, 0, 1, 0);

      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         bit w;
         w = ($urandom_range(3) == 0);
         if ($urandom_range(40) == 0) cap_run = ~cap_run;
         cyc(w, 3'($urandom_range(7)), $urandom,
             $urandom_range(30) == 0, 1'($urandom_range(1)),
             $urandom_range(3) == 0, $urandom_range(2) == 0);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule